// File: doc/BRIEF.md
# Register Slave with Adjustable Read Response Timing

This block is a memory-mapped register slave with a waitrequest/readdatavalid style handshake. It is meant as a test target for interconnect and protocol checkers. It holds a parameterized bank of data registers. Each register can be written one byte lane at a time, and every access can be stalled for a fixed number of cycles.

Parameters shape the read response. One parameter selects whether a separate readdatavalid strobe is driven at all. When it is not driven, read data is valid in the cycle the read is accepted. A second parameter sets the distance, in cycles, from the accepting cycle (waitrequest low) to the readdatavalid pulse. That distance may be zero, so a same-cycle response can be produced on purpose. A checker that wants at least one cycle of latency can then be shown to flag it. Only one read may be in flight at a time.

Top module: `lat_reg_slave`

## Requirements
- R1: While the reset input is low, and for the two cycles of reset synchronisation after it rises, waitrequest is high whatever the command inputs do.
- R2: A command (read or write high) with no read response outstanding sees waitrequest high for exactly WAIT_CYC cycles. waitrequest is low in the next cycle, which is the accepting cycle.
- R3: A write accepted with a legal byteenable updates exactly the enabled byte lanes; lane i covers data bits 8i+7..8i. The legal patterns are a naturally aligned group of 1, 2, 4 … lanes. With four lanes these are 0001, 0010, 0100, 1000, 0011, 1100 and 1111.
- R4: A write with any other byteenable pattern, 0000 included, leaves the register unchanged. A read with such a pattern returns zero.
- R5: An address at or above NUM_REGS reads as zero, and writes to it change no register.
- R6: With the strobe enabled and RESP_LAT ≥ 1, readdatavalid is a one-cycle pulse exactly RESP_LAT cycles after the accepting cycle. readdata carries the register value in that cycle.
- R7: With the strobe enabled and RESP_LAT = 0, readdatavalid is high in the accepting cycle of the read, together with the read data.
- R8: With the strobe disabled, readdatavalid stays low and readdata is valid in the accepting cycle of the read.
- R9: While a read response is outstanding, waitrequest stays high for any new command. The WAIT_CYC count for that command starts only after the readdatavalid cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| address | input | ADDR_W | Register index |
| read | input | 1 | Read command, held until accepted |
| write | input | 1 | Write command, held until accepted |
| byteenable | input | DATA_W/8 | Byte lane mask |
| writedata | input | DATA_W | Write data |
| waitrequest | output | 1 | High while the command is not being accepted |
| readdata | output | DATA_W | Read data |
| readdatavalid | output | 1 | Read response strobe (held low when the strobe is disabled) |

## Verification
On every cycle, the assertions check the handshake timing. They check that waitrequest is high in reset and while a read is outstanding. They check that each accepting cycle follows exactly WAIT_CYC stalled cycles, that the response pulse lands exactly RESP_LAT cycles after acceptance and lasts one cycle, and that the zero-latency strobe coincides with acceptance. Data content can only be shown by the bench's scenarios. This covers the byte-lane merges across all sixteen byteenable patterns, the zeroed reads for illegal masks and out-of-range addresses, and the ignored writes. It also covers the pending-read stall across three configurations: delayed strobe, same-cycle strobe and no strobe.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

  typedef enum logic [1:0] {
    LRS_STROBE_OFF   = 2'd0,
    LRS_STROBE_SAME  = 2'd1,
    LRS_STROBE_DELAY = 2'd2
  } lrs_strobe_e;

  // Legal masks: one naturally aligned group of 1, 2, 4, ... lanes.
  function automatic logic be_is_legal(input logic [31:0] be, input int unsigned lanes);
    logic ok;
    ok = 1'b0;
    for (int p = 0; p < 6; p++) begin
      for (int k = 0; k < 32; k++) begin
        int unsigned sz;
        sz = 32'd1 << p;
        if ((sz <= lanes) && ((k % sz) == 0) && ((k + sz) <= lanes)) begin
          if (be == 32'(((64'd1 << sz) - 64'd1) << k)) ok = 1'b1;
        end
      end
    end
    return ok;
  endfunction

  function automatic lrs_strobe_e strobe_mode(input int use_rdv, input int lat);
    if (use_rdv == 0) return LRS_STROBE_OFF;
    if (lat == 0)     return LRS_STROBE_SAME;
    return LRS_STROBE_DELAY;
  endfunction

endpackage

// File: rtl/lrs_handshake.sv
module lrs_handshake #(
  parameter int WAIT_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd,
  input  logic busy,
  output logic accept
);
  localparam int CNT_W = $clog2(WAIT_CYC + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(WAIT_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    accept = rst_n & cmd & ~busy & (cnt_q == CNT_TOP);
  end

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!cmd || accept) begin
      cnt_d  = '0;
      cnt_en = (cnt_q != '0);
    end else if (!busy && (cnt_q != CNT_TOP)) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/lrs_regfile.sv
module lrs_regfile
  import lrs_pkg::*;
#(
  parameter int NUM_REGS = 6,
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_acc,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W/8-1:0]  be,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rd_word
);
  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] word [NUM_REGS];
  logic              be_ok;
  logic [NUM_REGS-1:0] sel;

  always_comb be_ok = be_is_legal(32'(be), LANES);

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      always_comb sel[i] = (addr == ADDR_W'(i));
      for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [7:0] byte_q;
        logic       byte_en;
        always_comb byte_en = wr_acc & be_ok & sel[i] & be[j];
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)       byte_q <= '0;
          else if (byte_en) byte_q <= wdata[j*8 +: 8];
        end
        assign word[i][j*8 +: 8] = byte_q;
      end
    end
  endgenerate

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (sel[i] && be_ok) rd_word = word[i];
    end
  end

endmodule

// File: rtl/lrs_resp.sv
module lrs_resp
  import lrs_pkg::*;
#(
  parameter int USE_RDV  = 1,
  parameter int RESP_LAT = 1,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_acc,
  input  logic [DATA_W-1:0] rd_word,
  output logic              busy,
  output logic              rdv,
  output logic [DATA_W-1:0] rdata
);
  localparam lrs_strobe_e MODE = strobe_mode(USE_RDV, RESP_LAT);

  generate
    if (MODE == LRS_STROBE_DELAY) begin : g_delay
      localparam int LW = $clog2(RESP_LAT + 1) + 1;
      logic              pend_q, pend_d;
      logic [LW-1:0]     dcnt_q, dcnt_d;
      logic [DATA_W-1:0] hold_q;
      logic              fire;

      always_comb begin
        fire   = pend_q & (dcnt_q == '0);
        pend_d = pend_q;
        dcnt_d = dcnt_q;
        if (rd_acc) begin
          pend_d = 1'b1;
          dcnt_d = LW'(RESP_LAT - 1);
        end else if (fire) begin
          pend_d = 1'b0;
        end else if (pend_q) begin
          dcnt_d = dcnt_q - 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pend_q <= 1'b0;
          dcnt_q <= '0;
        end else begin
          pend_q <= pend_d;
          dcnt_q <= dcnt_d;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      hold_q <= '0;
        else if (rd_acc) hold_q <= rd_word;
      end

      assign busy  = pend_q;
      assign rdv   = fire;
      assign rdata = fire ? hold_q : '0;
    end else begin : g_direct
      assign busy  = 1'b0;
      assign rdv   = (MODE == LRS_STROBE_SAME) ? rd_acc : 1'b0;
      assign rdata = rd_acc ? rd_word : '0;
    end
  endgenerate

endmodule

// File: rtl/lat_reg_slave.sv
module lat_reg_slave #(
  parameter int NUM_REGS = 6,
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 32,
  parameter int USE_RDV  = 1,
  parameter int RESP_LAT = 1,
  parameter int WAIT_CYC = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   address,
  input  logic                read,
  input  logic                write,
  input  logic [DATA_W/8-1:0] byteenable,
  input  logic [DATA_W-1:0]   writedata,
  output logic                waitrequest,
  output logic [DATA_W-1:0]   readdata,
  output logic                readdatavalid
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  logic              accept;
  logic              busy;
  logic [DATA_W-1:0] rd_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  lrs_handshake #(.WAIT_CYC(WAIT_CYC)) u_hs (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .cmd    (read | write),
    .busy   (busy),
    .accept (accept)
  );

  lrs_regfile #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_acc  (accept & write),
    .addr    (address),
    .be      (byteenable),
    .wdata   (writedata),
    .rd_word (rd_word)
  );

  lrs_resp #(.USE_RDV(USE_RDV), .RESP_LAT(RESP_LAT), .DATA_W(DATA_W)) u_resp (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .rd_acc  (accept & read & ~write),
    .rd_word (rd_word),
    .busy    (busy),
    .rdv     (readdatavalid),
    .rdata   (readdata)
  );

  assign waitrequest = ~accept;

endmodule

// File: rtl/lat_reg_slave_checker.sv
module lat_reg_slave_checker #(
  parameter int USE_RDV  = 1,
  parameter int RESP_LAT = 1,
  parameter int WAIT_CYC = 1
) (
  input logic clk,
  input logic rst_n,
  input logic rst_sync,
  input logic read,
  input logic write,
  input logic waitrequest,
  input logic readdatavalid
);
  localparam int HW = $clog2(WAIT_CYC + 1) + 2;
  localparam int AW = $clog2(RESP_LAT + 1) + 2;

  logic          cmd, acc, rd_acc;
  logic          out_q;
  logic [AW-1:0] age_q;
  logic [HW-1:0] hold_q;

  assign cmd    = read | write;
  assign acc    = cmd & ~waitrequest;
  assign rd_acc = acc & read & ~write;

  // Own count of stalled cycles of the current command.
  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync)                     hold_q <= '0;
    else if (!cmd || acc)              hold_q <= '0;
    else if (!out_q && hold_q != '1)   hold_q <= hold_q + 1'b1;
  end

  // Own record of an outstanding delayed read.
  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      out_q <= 1'b0;
      age_q <= '0;
    end else if (USE_RDV != 0 && RESP_LAT > 0 && rd_acc) begin
      out_q <= 1'b1;
      age_q <= AW'(1);
    end else if (readdatavalid) begin
      out_q <= 1'b0;
    end else if (out_q && age_q != '1) begin
      age_q <= age_q + 1'b1;
    end
  end

  // R1: stalled while the reset input is low
  always_comb begin
    if (rst_n === 1'b0) begin
      p_wait_in_reset_r1: assert (waitrequest === 1'b1);
    end
  end

  // R2: acceptance only after exactly WAIT_CYC stalled cycles
  p_wait_count_r2: assert property (@(posedge clk) disable iff (!rst_sync)
    acc |-> (hold_q == HW'(WAIT_CYC)));

  generate
    if (USE_RDV != 0 && RESP_LAT > 0) begin : g_delayed
      // R6: pulse lands RESP_LAT cycles after acceptance
      p_strobe_latency_r6: assert property (@(posedge clk) disable iff (!rst_sync)
        readdatavalid |-> (out_q && age_q == AW'(RESP_LAT)));
      // R6: one-cycle pulse
      p_strobe_pulse_r6: assert property (@(posedge clk) disable iff (!rst_sync)
        readdatavalid |=> !readdatavalid);
      // R9: no acceptance while a read is outstanding
      p_one_outstanding_r9: assert property (@(posedge clk) disable iff (!rst_sync)
        out_q |-> waitrequest);
    end else if (USE_RDV != 0) begin : g_same
      // R7: strobe coincides with read acceptance
      p_same_cycle_r7: assert property (@(posedge clk) disable iff (!rst_sync)
        readdatavalid == rd_acc);
    end
  endgenerate

endmodule

bind lat_reg_slave lat_reg_slave_checker #(
  .USE_RDV(USE_RDV), .RESP_LAT(RESP_LAT), .WAIT_CYC(WAIT_CYC)
) u_lat_reg_slave_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .rst_sync      (rst_n_int),
  .read          (read),
  .write         (write),
  .waitrequest   (waitrequest),
  .readdatavalid (readdatavalid)
);

// File: tb/lat_reg_slave_bench.sv
`timescale 1ns/1ps
module lat_reg_slave_bench;
  localparam int NI = 3;
  localparam int NR = 6;
  localparam int P_USE [NI]  = '{1, 1, 0};
  localparam int P_LAT [NI]  = '{2, 0, 3};
  localparam int P_WAIT[NI]  = '{1, 0, 2};

  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  logic        rd  [NI];
  logic        wr  [NI];
  logic [2:0]  adr [NI];
  logic [3:0]  be  [NI];
  logic [31:0] wd  [NI];
  logic        wt  [NI];
  logic        rdv [NI];
  logic [31:0] rdat[NI];

  generate
    for (genvar k = 0; k < NI; k++) begin : g_dut
      lat_reg_slave #(
        .NUM_REGS(NR), .ADDR_W(3), .DATA_W(32),
        .USE_RDV(P_USE[k]), .RESP_LAT(P_LAT[k]), .WAIT_CYC(P_WAIT[k])
      ) u_lat_reg_slave (
        .clk(clk), .rst_n(rst_n), .address(adr[k]), .read(rd[k]), .write(wr[k]),
        .byteenable(be[k]), .writedata(wd[k]), .waitrequest(wt[k]),
        .readdata(rdat[k]), .readdatavalid(rdv[k])
      );
    end
  endgenerate

  int errors = 0;
  int checks = 0;
  bit done   = 0;
  logic [31:0] model [NI][8];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit legal4(input logic [3:0] b);
    return (b inside {4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0011, 4'b1100, 4'b1111});
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d, input logic [3:0] b);
    logic [31:0] r;
    r = old;
    for (int j = 0; j < 4; j++) if (b[j]) r[j*8 +: 8] = d[j*8 +: 8];
    return r;
  endfunction

  // Called just after a falling edge; returns just after a falling edge.
  task automatic access(input int k, input bit is_wr, input logic [2:0] a, input logic [3:0] b,
                        input logic [31:0] d, output logic [31:0] got, output int waits,
                        output int lat_seen, output int pulses);
    rd[k] = !is_wr; wr[k] = is_wr; adr[k] = a; be[k] = b; wd[k] = d;
    waits = 0; got = '0; lat_seen = -1; pulses = 0;
    #1;
    while (wt[k] === 1'b1) begin
      waits++;
      @(negedge clk); #1;
    end
    if (!is_wr && (P_USE[k] == 0 || P_LAT[k] == 0)) begin
      got = rdat[k];
      if (rdv[k]) begin lat_seen = 0; pulses++; end
    end
    @(negedge clk);
    rd[k] = 1'b0; wr[k] = 1'b0;
    if (!is_wr) begin
      for (int n = 1; n <= P_LAT[k] + 1; n++) begin
        #1;
        if (rdv[k]) begin
          pulses++;
          if (lat_seen < 0) lat_seen = n;
          got = rdat[k];
        end
        @(negedge clk);
      end
    end
  endtask

  task automatic do_write(input int k, input logic [2:0] a, input logic [3:0] b, input logic [31:0] d);
    logic [31:0] g; int w, l, p;
    access(k, 1'b1, a, b, d, g, w, l, p);
    chk($sformatf("R2 write wait inst%0d", k), w, P_WAIT[k]);
    if (a < NR && legal4(b)) model[k][a] = merge(model[k][a], d, b);
  endtask

  task automatic do_read(input int k, input logic [2:0] a, input logic [3:0] b, input string req);
    logic [31:0] g; int w, l, p;
    logic [31:0] exp;
    access(k, 1'b0, a, b, '0, g, w, l, p);
    exp = (a < NR && legal4(b)) ? model[k][a] : 32'h0;
    chk($sformatf("%s data inst%0d addr%0d be%b", req, k, a, b), g, exp);
    chk($sformatf("R2 read wait inst%0d", k), w, P_WAIT[k]);
    if (P_USE[k] == 0) begin
      chk("R8 no strobe", p, 0);
    end else if (P_LAT[k] == 0) begin
      chk("R7 same-cycle strobe", l, 0);
      chk("R7 strobe count", p, 1);
    end else begin
      chk("R6 strobe latency", l, P_LAT[k]);
      chk("R6 single pulse", p, 1);
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NI; k++) begin
      rd[k] = 0; wr[k] = 0; adr[k] = 0; be[k] = 0; wd[k] = 0;
      for (int a = 0; a < 8; a++) model[k][a] = '0;
    end
    rst_n = 1'b0;
    @(negedge clk);
    for (int k = 0; k < NI; k++) begin rd[k] = 1; wr[k] = (k == 1); end
    for (int c = 0; c < 4; c++) begin
      #1;
      for (int k = 0; k < NI; k++) chk($sformatf("R1 wait in reset inst%0d", k), wt[k], 1'b1);
      @(negedge clk);
    end
    rst_n = 1'b1;
    #1;
    for (int k = 0; k < NI; k++) chk($sformatf("R1 wait during sync inst%0d", k), wt[k], 1'b1);
    for (int k = 0; k < NI; k++) begin rd[k] = 0; wr[k] = 0; end
    repeat (4) @(negedge clk);

    // Reset values read back as zero.
    for (int k = 0; k < NI; k++) do_read(k, 3'd0, 4'hF, "R1 reset value");

    // Full-word writes and reads over every address, including out of range.
    for (int k = 0; k < NI; k++) begin
      for (int a = 0; a < 8; a++)
        do_write(k, 3'(a), 4'hF, 32'h0000_00A5 ^ (32'(a) * 32'h0101_0101) ^ (32'(k) << 28));
      for (int a = 0; a < 8; a++)
        do_read(k, 3'(a), 4'hF, (a < NR) ? "R3" : "R5");
    end

    // Every byteenable pattern on register 3, read back whole and with the same mask.
    for (int k = 0; k < NI; k++) begin
      for (int b = 0; b < 16; b++) begin
        do_write(k, 3'd3, 4'(b), ~(32'(b) * 32'h1111_1111) ^ 32'h5A00_0000);
        do_read(k, 3'd3, 4'hF, legal4(4'(b)) ? "R3" : "R4 write");
        do_read(k, 3'd3, 4'(b), legal4(4'(b)) ? "R3" : "R4 read");
      end
      do_read(k, 3'd4, 4'hF, "R4 neighbour");
    end

    // Back-to-back reads on the delayed-strobe instance.
    begin
      int waits2, nrdv, seen;
      logic [31:0] d1, d2;
      rd[0] = 1; adr[0] = 3'd1; be[0] = 4'hF;
      #1;
      while (wt[0] === 1'b1) begin @(negedge clk); #1; end
      @(negedge clk);
      adr[0] = 3'd2;
      waits2 = 0; nrdv = 0; seen = -1; d1 = '0;
      for (int n = 1; n < 20; n++) begin
        #1;
        if (rdv[0]) begin nrdv++; seen = n; d1 = rdat[0]; end
        if (wt[0] !== 1'b1) break;
        waits2++;
        @(negedge clk);
      end
      chk("R9 stall while read outstanding", waits2, P_LAT[0] + P_WAIT[0]);
      chk("R9 first strobe position", seen, P_LAT[0]);
      chk("R9 first strobe data", d1, model[0][1]);
      chk("R9 first strobe count", nrdv, 1);
      @(negedge clk);
      rd[0] = 0;
      seen = -1; d2 = '0;
      for (int n = 1; n <= P_LAT[0] + 1; n++) begin
        #1;
        if (rdv[0] && seen < 0) begin seen = n; d2 = rdat[0]; end
        @(negedge clk);
      end
      chk("R6 second strobe position", seen, P_LAT[0]);
      chk("R6 second strobe data", d2, model[0][2]);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule